// File: doc/BRIEF.md
# Per-Cycle Bus Width Adapter

This unit sits between a 32-bit transfer source and an external data bus whose width is chosen anew for every bus cycle. The source hands over one transfer: four active-high byte enables, a doubleword address, a direction and a 32-bit write word. The unit then runs one or two external bus cycles and returns a merged 32-bit read word. The external side ends each cycle with an active-low ready input. It reports the width of the cycle on an active-low narrow input, which is sampled in the same clock as ready. When the narrow input is low, only lines 15:0 carry data in that cycle.

The request side is valid/ready. A request is taken in the clock where `req_valid` and `req_ready` are both high. `req_ready` stays low from that point until the response has been accepted, so the source simply holds its request while `req_ready` is low. The response side is also valid/ready. `rsp_valid` rises once the last bus cycle ends, and it holds with stable data until `rsp_ready` is seen high. The unit can stall without limit on either side.

If a transfer enables bytes in both halves and the bus answers narrow, the unit runs a second cycle on its own for bytes 3:2. In that cycle it moves the write bytes down onto lines 15:0, and it steers the returned lines 15:0 up into bytes 3:2 of the result.

Top module: `bsz_unit`

## Requirements
- R1: After reset the unit is idle. `req_ready` is high, and `bus_cyc`, `bus_ads` and `rsp_valid` are low.
- R2: A request is accepted in the clock where `req_valid` and `req_ready` are both high. The first state of the bus cycle (`bus_ads`=1, `bus_cyc`=1) follows in the next clock, and `req_ready` stays low until the response is accepted.
- R3: Every bus cycle lasts at least two clocks. `bus_ads` is high only in the first clock. `bus_rdy_n` is ignored in that first clock and sampled in every later clock until it is seen low.
- R4: If `bus_size16_n` is high when ready is sampled low in the first cycle, the transfer finishes in that single cycle. `bus_be` equals the requested enables, and every write byte k sits on its own lane, bits 8k+7:8k.
- R5: In the first cycle, lines 15:0 carry write bytes 1:0 when either of enables 1:0 is set. Otherwise they carry copies of write bytes 3:2 (byte 2 on 7:0, byte 3 on 15:8). Lines 31:16 always carry write bytes 3:2.
- R6: If enables fall in only one half and the cycle ends with `bus_size16_n` low, one cycle suffices. With enables 1:0 only, result bytes 1:0 come from lines 15:0. With enables 3:2 only, result bytes 3:2 come from lines 15:0.
- R7: If enables fall in both halves and the first cycle ends with `bus_size16_n` low, a second cycle starts in the next clock. It uses the same address and direction, and `bus_be` equals the requested enables with bits 1:0 cleared. Write bytes 3:2 appear on lines 7:0 and 15:8.
- R8: In that second cycle `bus_size16_n` has no effect. Its lines 15:0 always supply result bytes 3:2, and the transfer always ends with that cycle.
- R9: The result of a read sets each byte whose enable was clear to zero. In an unsplit wide cycle each enabled byte k comes from lines 8k+7:8k. In a split transfer bytes 1:0 come from the first cycle's lines 15:0.
- R10: `rsp_valid` rises only after the final bus cycle has ended, and never while `bus_cyc` is high. It holds with unchanged `rsp_rdata` while `rsp_ready` is low. For a write, `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Unit can take a request |
| req_be | input | 4 | Byte enables, bit k for byte k, active high |
| req_addr | input | ADDR_W | Doubleword address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write word |
| rsp_valid | output | 1 | Transfer finished, result present |
| rsp_ready | input | 1 | Source takes the result |
| rsp_rdata | output | DATA_W | Merged read word (zero for writes) |
| bus_cyc | output | 1 | External bus cycle in progress |
| bus_ads | output | 1 | First clock of a bus cycle |
| bus_addr | output | ADDR_W | Address driven in the cycle |
| bus_be | output | 4 | Byte enables driven in the cycle |
| bus_write | output | 1 | Direction of the cycle |
| bus_wdata | output | DATA_W | Write lanes driven in the cycle |
| bus_rdata | input | DATA_W | Read lanes from the bus |
| bus_rdy_n | input | 1 | Cycle end, active low |
| bus_size16_n | input | 1 | Narrow cycle, active low, sampled with ready |

## Verification
Every one of the fifteen nonzero enable patterns is run as a read and as a write, once with the bus answering wide and once answering narrow. These runs separate the single-cycle wide path, the two single-half narrow paths (lower-only against upper-only lane steering) and the split path. Random transfers add random wait states and random read data. They also drive a false early ready in the first clock of each cycle and a random width on the second cycle, which shows whether the first-clock sample or the follow-up width leaks into the count of cycles or the merged word. Response back-pressure of one clock is applied on every transfer to show that the result holds steady.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_RESP = 2'd3
  } bsz_state_e;

  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/bsz_ctrl.sv
module bsz_ctrl
  import bsz_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_fire,
  input  logic       both_halves,
  input  logic       rdy_n,
  input  logic       size16_n,
  input  logic       rsp_ready,
  output bsz_state_e state,
  output logic       upper_phase,
  output logic       cyc_end,
  output logic       split_go
);
  bsz_state_e state_d;
  logic       phase_d;

  assign cyc_end  = (state == ST_DATA) && !rdy_n;
  assign split_go = cyc_end && !upper_phase && both_halves && !size16_n;

  always_comb begin
    state_d = state;
    phase_d = upper_phase;
    unique case (state)
      ST_IDLE: if (req_fire) begin
        state_d = ST_ADDR;
        phase_d = 1'b0;
      end
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: if (cyc_end) begin
        if (split_go) begin
          state_d = ST_ADDR;
          phase_d = 1'b1;
        end else begin
          state_d = ST_RESP;
        end
      end
      ST_RESP: if (rsp_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      upper_phase <= 1'b0;
    end else begin
      state       <= state_d;
      upper_phase <= phase_d;
    end
  end
endmodule

// File: rtl/bsz_lane_steer.sv
module bsz_lane_steer #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                upper_phase,
  input  logic                active,
  output logic [DATA_W/8-1:0] bus_be,
  output logic [DATA_W-1:0]   bus_wdata
);
  localparam int unsigned HALF_W  = DATA_W / 2;
  localparam int unsigned HALF_BE = DATA_W / 16;

  logic lo_none;
  logic [HALF_W-1:0] lo_lanes;

  assign lo_none  = (be[HALF_BE-1:0] == '0);
  assign lo_lanes = (upper_phase || lo_none) ? wdata[DATA_W-1:HALF_W] : wdata[HALF_W-1:0];

  always_comb begin
    bus_be    = '0;
    bus_wdata = '0;
    if (active) begin
      bus_be    = upper_phase ? {be[DATA_W/8-1:HALF_BE], {HALF_BE{1'b0}}} : be;
      bus_wdata = {wdata[DATA_W-1:HALF_W], lo_lanes};
    end
  end
endmodule

// File: rtl/bsz_rd_merge.sv
module bsz_rd_merge #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                cyc_end,
  input  logic                split_go,
  input  logic                upper_phase,
  input  logic                narrow,
  input  logic [DATA_W/8-1:0] be,
  input  logic                is_write,
  input  logic [DATA_W-1:0]   rdata,
  output logic [DATA_W-1:0]   merged
);
  localparam int unsigned NBYTE   = DATA_W / 8;
  localparam int unsigned HALF_BE = NBYTE / 2;

  logic lo_none;
  logic take_lo;
  logic take_up;
  logic up_from_low;

  assign lo_none     = (be[HALF_BE-1:0] == '0);
  assign take_lo     = cyc_end && !upper_phase;
  assign take_up     = cyc_end && !split_go;
  assign up_from_low = upper_phase || (narrow && lo_none);

  for (genvar i = 0; i < NBYTE; i++) begin : g_byte
    logic [7:0] src;
    logic       take;
    if (i < HALF_BE) begin : g_lo
      assign src  = rdata[8*i +: 8];
      assign take = take_lo;
    end else begin : g_up
      assign src  = up_from_low ? rdata[8*(i-HALF_BE) +: 8] : rdata[8*i +: 8];
      assign take = take_up;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        merged[8*i +: 8] <= '0;
      end else if (clear) begin
        merged[8*i +: 8] <= '0;
      end else if (take) begin
        merged[8*i +: 8] <= (be[i] && !is_write) ? src : 8'h00;
      end
    end
  end
endmodule

// File: rtl/bsz_unit.sv
module bsz_unit
  import bsz_pkg::*;
#(
  parameter int unsigned ADDR_W = 30,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_write,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                bus_cyc,
  output logic                bus_ads,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W/8-1:0] bus_be,
  output logic                bus_write,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W-1:0]   bus_rdata,
  input  logic                bus_rdy_n,
  input  logic                bus_size16_n
);
  localparam int unsigned NBYTE   = DATA_W / 8;
  localparam int unsigned HALF_BE = NBYTE / 2;

  bsz_state_e          state;
  logic                upper_phase;
  logic                cyc_end;
  logic                split_go;
  logic                req_fire;
  logic [NBYTE-1:0]    be_q;
  logic [ADDR_W-1:0]   addr_q;
  logic                we_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                both_halves;

  assign req_ready   = (state == ST_IDLE);
  assign req_fire    = req_valid && req_ready;
  assign rsp_valid   = (state == ST_RESP);
  assign bus_cyc     = (state == ST_ADDR) || (state == ST_DATA);
  assign bus_ads     = (state == ST_ADDR);
  assign bus_addr    = addr_q;
  assign bus_write   = we_q;
  assign both_halves = (be_q[HALF_BE-1:0] != '0) && (be_q[NBYTE-1:HALF_BE] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_q    <= '0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (req_fire) begin
      be_q    <= req_be;
      addr_q  <= req_addr;
      we_q    <= req_write;
      wdata_q <= req_wdata;
    end
  end

  bsz_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_fire    (req_fire),
    .both_halves (both_halves),
    .rdy_n       (bus_rdy_n),
    .size16_n    (bus_size16_n),
    .rsp_ready   (rsp_ready),
    .state       (state),
    .upper_phase (upper_phase),
    .cyc_end     (cyc_end),
    .split_go    (split_go)
  );

  bsz_lane_steer #(.DATA_W(DATA_W)) u_steer (
    .be          (be_q),
    .wdata       (wdata_q),
    .upper_phase (upper_phase),
    .active      (bus_cyc),
    .bus_be      (bus_be),
    .bus_wdata   (bus_wdata)
  );

  bsz_rd_merge #(.DATA_W(DATA_W)) u_merge (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (req_fire),
    .cyc_end     (cyc_end),
    .split_go    (split_go),
    .upper_phase (upper_phase),
    .narrow      (!bus_size16_n),
    .be          (be_q),
    .is_write    (we_q),
    .rdata       (bus_rdata),
    .merged      (rsp_rdata)
  );
endmodule

// File: rtl/bsz_unit_chk.sv
module bsz_unit_chk #(
  parameter int unsigned ADDR_W = 30,
  parameter int unsigned DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [DATA_W-1:0]   rsp_rdata,
  input logic                bus_cyc,
  input logic                bus_ads,
  input logic [DATA_W/8-1:0] bus_be
);
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> bus_ads && !req_ready); // R2
  AST_ADS_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ads |=> !bus_ads && bus_cyc); // R3
  AST_ADS_INSIDE_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ads |-> bus_cyc); // R3
  AST_BE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && !bus_ads |-> $stable(bus_be)); // R3
  AST_FOLLOWUP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ads && $past(bus_cyc) |-> (bus_be[1:0] == 2'b00) && (bus_be[3:2] != 2'b00)); // R7
  AST_RSP_NOT_IN_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && bus_cyc)); // R10
  AST_RSP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R10
endmodule

bind bsz_unit bsz_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .bus_cyc   (bus_cyc),
  .bus_ads   (bus_ads),
  .bus_be    (bus_be)
);

// File: tb/bsz_unit_tb.sv
module bsz_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_be = '0;
  logic [29:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic        bus_cyc;
  logic        bus_ads;
  logic [29:0] bus_addr;
  logic [3:0]  bus_be;
  logic        bus_write;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        bus_rdy_n = 1'b1;
  logic        bus_size16_n = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bsz_unit u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_lanes1(input logic [3:0] be, input logic [31:0] w);
    logic [15:0] lo;
    lo = (be[0] || be[1]) ? w[15:0] : w[31:16];
    return {w[31:16], lo};
  endfunction

  function automatic logic [31:0] exp_result(input logic [3:0] be, input bit wr, input bit narrow,
                                             input logic [31:0] d1, input logic [31:0] d2);
    logic [31:0] r;
    bit split;
    r = '0;
    split = narrow && (be[1:0] != 0) && (be[3:2] != 0);
    if (wr) return '0;
    for (int k = 0; k < 4; k++) begin
      if (be[k]) begin
        if (!narrow || k < 2) r[8*k +: 8] = d1[8*k +: 8];
        else if (split)       r[8*k +: 8] = d2[8*(k-2) +: 8];
        else                  r[8*k +: 8] = d1[8*(k-2) +: 8];
      end
    end
    return r;
  endfunction

  // One bus cycle seen from the bus side, starting at the negedge inside its first clock.
  task automatic serve_cycle(input int waits, input bit narrow_n, input logic [31:0] d);
    chk(bus_ads && bus_cyc, "R3 first clock", {30'b0, bus_cyc, bus_ads}, 32'h3);
    bus_rdy_n = 1'b0;
    bus_size16_n = ~narrow_n;
    bus_rdata = ~d;
    @(negedge clk);
    chk(!bus_ads && bus_cyc, "R3 early ready ignored", {30'b0, bus_cyc, bus_ads}, 32'h2);
    for (int w = 0; w < waits; w++) begin
      bus_rdy_n = 1'b1;
      @(negedge clk);
      chk(bus_cyc && !bus_ads, "R3 wait state", {30'b0, bus_cyc, bus_ads}, 32'h2);
    end
    bus_rdy_n = 1'b0;
    bus_size16_n = narrow_n;
    bus_rdata = d;
    @(negedge clk);
    bus_rdy_n = 1'b1;
    bus_size16_n = 1'b1;
  endtask

  task automatic run_txn(input logic [3:0] be, input bit wr, input bit narrow,
                         input bit narrow2, input int waits);
    logic [31:0] w, d1, d2, expr;
    logic [29:0] a;
    bit split;
    w = $urandom; d1 = $urandom; d2 = $urandom; a = 30'($urandom);
    split = narrow && (be[1:0] != 0) && (be[3:2] != 0);
    req_valid = 1'b1; req_be = be; req_write = wr; req_wdata = w; req_addr = a;
    chk(req_ready, "R2 ready when idle", {31'b0, req_ready}, 32'h1);
    @(negedge clk);
    req_valid = 1'b0; req_be = '0; req_wdata = '0;
    chk(!req_ready && bus_ads, "R2 cycle starts", {30'b0, req_ready, bus_ads}, 32'h1);
    chk(bus_be == be, "R4 first enables", {28'b0, bus_be}, {28'b0, be});
    chk(bus_wdata == exp_lanes1(be, w), "R5 first write lanes", bus_wdata, exp_lanes1(be, w));
    chk(bus_addr == a && bus_write == wr, "R2 address", {1'b0, bus_write, bus_addr}, {1'b0, wr, a});
    serve_cycle(waits, !narrow, d1);
    if (split) begin
      chk(bus_ads && bus_be == {be[3:2], 2'b00}, "R7 follow-up enables", {27'b0, bus_ads, bus_be},
          {27'b0, 1'b1, be[3:2], 2'b00});
      chk(bus_wdata[15:0] == w[31:16] && bus_addr == a, "R7 follow-up lanes",
          {16'b0, bus_wdata[15:0]}, {16'b0, w[31:16]});
      serve_cycle(waits, !narrow2, d2);
    end
    expr = exp_result(be, wr, narrow, d1, d2);
    chk(rsp_valid && !bus_cyc, "R10 response after final cycle", {30'b0, rsp_valid, bus_cyc}, 32'h2);
    if (narrow) chk(rsp_rdata == expr, split ? "R8 split merge" : "R6 narrow single", rsp_rdata, expr);
    else        chk(rsp_rdata == expr, "R9 wide merge", rsp_rdata, expr);
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == expr, "R10 hold under back-pressure", rsp_rdata, expr);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R2 back to idle", {30'b0, rsp_valid, req_ready}, 32'h1);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected below 100000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_0386));
    repeat (3) @(negedge clk);
    chk(req_ready && !bus_cyc && !bus_ads && !rsp_valid, "R1 reset state",
        {28'b0, req_ready, bus_cyc, bus_ads, rsp_valid}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !bus_cyc && !rsp_valid, "R1 idle after reset",
        {29'b0, req_ready, bus_cyc, rsp_valid}, 32'h4);
    for (int b = 1; b < 16; b++)
      for (int m = 0; m < 4; m++)
        run_txn(4'(b), m[0], m[1], m[0], m % 3);
    run_txn(4'b1111, 1'b0, 1'b1, 1'b0, 0); // R8 wide answer on follow-up ignored
    run_txn(4'b0110, 1'b1, 1'b1, 1'b1, 2); // R7 straddling write
    run_txn(4'b1100, 1'b0, 1'b1, 1'b1, 1); // R6 upper only
    for (int t = 0; t < 60; t++) begin
      logic [3:0] be;
      be = 4'($urandom_range(1, 15));
      run_txn(be, 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom_range(0, 3)));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule